// File: doc/BRIEF.md
# Programmable chip-select address decoder

This block decides, for each bus address, which memory or peripheral regions it falls into. It holds a small bank of select channels. Each channel has a base address, a 3-bit size code, an enable bit, a pin-mode bit, a port-width bit and a wait-state count. When an enabled channel's window contains the presented address, the block drives that channel's active-low select output. The size code picks a non-uniform set of upper address bits to compare. The block also reports a cycle-level match flag, which bus logic uses to return an acknowledge. It reports the width and wait count of the winning channel with that flag.

A channel whose pin has been given over to some other use still takes part in matching. It raises the match flag, but its select output stays inactive. Channel programming goes through a single write port, one channel per clock. On reset, the boot channel comes up active and covers the bottom of the address space. It takes its port width from a strap level that is sampled while reset is held. Every other channel comes up disabled.

Top module: `csel_decoder`

## Requirements
- R1: While `rstN` is low, the boot channel (channel 0) is loaded with enable 1, base 0, size code 3'b111, pin mode 1 (pin drives a select) and wait count all ones. Every other channel is loaded with enable 0 and all fields zero.
- R2: The boot channel's port-width bit takes the level of `bootWide` at the last clock edge of reset. A 1 means 16-bit, reported as `hitWide`=1. A 0 means 8-bit, reported as `hitWide`=0.
- R3: The size code selects the lowest compared address bit. Code 0 compares from bit 11 (2 KB), code 1 from bit 13, code 2 from bit 14, code 3 from bit 16, code 4 from bit 17, code 5 from bit 18 and code 6 from bit 19. A channel matches when `addr[23:low]` equals `{base,11'b0}[23:low]`. Base bits below the compared range have no effect.
- R4: Code 7 compares bits 23:20 only, so address bit 19 is ignored. When bits 23:20 copy bit 19, this gives the same 512 KB window as code 6. With arbitrary addresses, the two codes differ in how they treat bit 19.
- R5: Outputs are registered. `selN`, `ackReq`, `hitWide` and `hitWait` reflect the `addr`/`addrValid` sampled at the previous rising edge. A cycle sampled with `addrValid` low produces all `selN` high, `ackReq` 0, `hitWide` 0 and `hitWait` 0.
- R6: A disabled channel never matches. Its `selN` bit stays high, and it does not contribute to `ackReq`, `hitWide` or `hitWait`.
- R7: A matching enabled channel with pin mode 0 raises `ackReq` but leaves its `selN` bit high. With pin mode 1, it drives its `selN` bit low.
- R8: When several enabled channels match, the lowest-numbered one supplies `hitWide` and `hitWait`. When none matches, both are 0.
- R9: A write with `wrEn` high loads base, size, enable, pin mode, width and wait into channel `wrChan`. The new values take effect for addresses sampled from the next edge on. A write presented while `rstN` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bootWide | input | 1 | Strap level sampled during reset for the boot channel width |
| wrEn | input | 1 | Channel write strobe |
| wrChan | input | CH_W | Channel index to write |
| wrBase | input | ADDR_W-11 | Base address bits [ADDR_W-1:11] |
| wrSize | input | 3 | Size code |
| wrEnable | input | 1 | Channel enable |
| wrPinSel | input | 1 | 1: pin drives a select; 0: pin used otherwise |
| wrWide | input | 1 | Port width, 1 = 16-bit |
| wrWait | input | WAIT_W | Wait-state count |
| addr | input | ADDR_W | Bus address |
| addrValid | input | 1 | Address qualifier |
| selN | output | NUM_CH | Registered active-low selects |
| ackReq | output | 1 | Registered match flag for any enabled channel |
| hitWide | output | 1 | Port width of the winning channel |
| hitWait | output | WAIT_W | Wait count of the winning channel |

## Verification
The assertions assume that the write port is quiet while reset is held, or at least that its contents do not matter there. They also assume that `addrValid` is a clean per-cycle qualifier and that channel indices are always within range. The stimulus changes inputs only on falling edges and writes only legal indices. It keeps channels whose windows overlap at equal wait counts and tells them apart by port width instead, so the priority rule is still observable. Address sweeps present arbitrary upper bits, including values where bits 23:20 disagree with bit 19, so that the two largest size codes can be told apart.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Upper bound on channel count carried through the strobe struct
  localparam int CSEL_MAX_CH = 16;
  // Finest window granularity: base registers hold bits above this
  localparam int CSEL_GRAIN = 11;

  typedef struct packed {
    logic [CSEL_MAX_CH-1:0] load;    // one-hot channel write strobe
    logic                   capture; // sample address this edge
    logic                   inReset; // load defaults this edge
  } cselStb_t;

  // Lowest address bit that takes part in the compare for a size code
  function automatic int unsigned cmpLowBit(input logic [2:0] code);
    case (code)
      3'd0:    cmpLowBit = 11;
      3'd1:    cmpLowBit = 13;
      3'd2:    cmpLowBit = 14;
      3'd3:    cmpLowBit = 16;
      3'd4:    cmpLowBit = 17;
      3'd5:    cmpLowBit = 18;
      3'd6:    cmpLowBit = 19;
      default: cmpLowBit = 20;
    endcase
  endfunction

endpackage

// File: rtl/csel_ctrl.sv
module csel_ctrl
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [CH_W-1:0] wrChan,
  input  logic            addrValid,
  output cselStb_t        stb
);

  always_comb begin
    stb         = '0;
    stb.inReset = !rstN;
    stb.capture = rstN && addrValid;
    for (int i = 0; i < NUM_CH; i++) begin
      stb.load[i] = rstN && wrEn && (wrChan == CH_W'(i));
    end
  end

endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 24,
  parameter int WAIT_W  = 4,
  parameter int BOOT_CH = 0,
  parameter int BASE_W  = ADDR_W - CSEL_GRAIN
) (
  input  logic              clk,
  input  cselStb_t          stb,
  input  logic              bootWide,
  input  logic [BASE_W-1:0] wrBase,
  input  logic [2:0]        wrSize,
  input  logic              wrEnable,
  input  logic              wrPinSel,
  input  logic              wrWide,
  input  logic [WAIT_W-1:0] wrWait,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] selN,
  output logic              ackReq,
  output logic              hitWide,
  output logic [WAIT_W-1:0] hitWait
);

  logic [BASE_W-1:0] baseQ [NUM_CH];
  logic [2:0]        sizeQ [NUM_CH];
  logic [WAIT_W-1:0] waitQ [NUM_CH];
  logic [NUM_CH-1:0] enQ, pinQ, wideQ;
  logic [NUM_CH-1:0] hitNow;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    localparam bit IS_BOOT = (g == BOOT_CH);
    logic [ADDR_W-1:0] cmpMask;

    always_ff @(posedge clk) begin
      if (stb.inReset) begin
        baseQ[g] <= '0;
        sizeQ[g] <= IS_BOOT ? 3'b111 : 3'b000;
        waitQ[g] <= IS_BOOT ? '1 : '0;
        enQ[g]   <= IS_BOOT;
        pinQ[g]  <= IS_BOOT;
        wideQ[g] <= IS_BOOT ? bootWide : 1'b0;
      end else if (stb.load[g]) begin
        baseQ[g] <= wrBase;
        sizeQ[g] <= wrSize;
        waitQ[g] <= wrWait;
        enQ[g]   <= wrEnable;
        pinQ[g]  <= wrPinSel;
        wideQ[g] <= wrWide;
      end
    end

    always_comb cmpMask = {ADDR_W{1'b1}} << cmpLowBit(sizeQ[g]);
    assign hitNow[g] = enQ[g] &&
      (((addr ^ {baseQ[g], {CSEL_GRAIN{1'b0}}}) & cmpMask) == '0);

    // R9
    load_chk: assert property (@(posedge clk) disable iff (stb.inReset)
      stb.load[g] |=> (baseQ[g] == $past(wrBase)) && (sizeQ[g] == $past(wrSize))
                      && (waitQ[g] == $past(wrWait)) && (enQ[g] == $past(wrEnable)));
    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (stb.inReset)
      (stb.capture && !enQ[g]) |=> selN[g]);
  end

  // Lowest-numbered matching channel wins the attributes
  logic              prioWide;
  logic [WAIT_W-1:0] prioWait;
  always_comb begin
    prioWide = 1'b0;
    prioWait = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hitNow[i]) begin
        prioWide = wideQ[i];
        prioWait = waitQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.inReset || !stb.capture) begin
      selN    <= '1;
      ackReq  <= 1'b0;
      hitWide <= 1'b0;
      hitWait <= '0;
    end else begin
      selN    <= ~(hitNow & pinQ);
      ackReq  <= |hitNow;
      hitWide <= prioWide;
      hitWait <= prioWait;
    end
  end

  // R1
  boot_default_chk: assert property (@(posedge clk) disable iff (stb.inReset)
    $fell(stb.inReset) |-> (enQ == (NUM_CH'(1) << BOOT_CH)) && (baseQ[BOOT_CH] == '0)
                           && (sizeQ[BOOT_CH] == 3'b111));
  // R2
  boot_width_chk: assert property (@(posedge clk) disable iff (stb.inReset)
    $fell(stb.inReset) |-> (wideQ[BOOT_CH] == $past(bootWide)));
  // R5
  idle_cycle_chk: assert property (@(posedge clk) disable iff (stb.inReset)
    !stb.capture |=> (&selN) && !ackReq);
  // R7
  sel_needs_ack_chk: assert property (@(posedge clk) disable iff (stb.inReset)
    !(&selN) |-> ackReq);
  // R8
  idle_attr_chk: assert property (@(posedge clk) disable iff (stb.inReset)
    !ackReq |-> (hitWait == '0) && !hitWide);

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 24,
  parameter int WAIT_W  = 4,
  parameter int BOOT_CH = 0,
  parameter int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       bootWide,
  input  logic                       wrEn,
  input  logic [CH_W-1:0]            wrChan,
  input  logic [ADDR_W-CSEL_GRAIN-1:0] wrBase,
  input  logic [2:0]                 wrSize,
  input  logic                       wrEnable,
  input  logic                       wrPinSel,
  input  logic                       wrWide,
  input  logic [WAIT_W-1:0]          wrWait,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       addrValid,
  output logic [NUM_CH-1:0]          selN,
  output logic                       ackReq,
  output logic                       hitWide,
  output logic [WAIT_W-1:0]          hitWait
);

  cselStb_t stb;

  csel_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan), .addrValid(addrValid), .stb(stb)
  );

  csel_datapath #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .BOOT_CH(BOOT_CH)
  ) u_dp (
    .clk(clk), .stb(stb), .bootWide(bootWide),
    .wrBase(wrBase), .wrSize(wrSize), .wrEnable(wrEnable), .wrPinSel(wrPinSel),
    .wrWide(wrWide), .wrWait(wrWait), .addr(addr),
    .selN(selN), .ackReq(ackReq), .hitWide(hitWide), .hitWait(hitWait)
  );

endmodule

// File: tb/csel_decoder_bench.sv
module csel_decoder_bench;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 24;
  localparam int WAIT_W = 4;
  localparam int CH_W   = 2;
  localparam int BASE_W = 13;
  localparam int OUT_W  = NUM_CH + WAIT_W + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0, bootWide = 1'b0, wrEn = 1'b0;
  logic [CH_W-1:0] wrChan = '0;
  logic [BASE_W-1:0] wrBase = '0;
  logic [2:0] wrSize = '0;
  logic wrEnable = 1'b0, wrPinSel = 1'b0, wrWide = 1'b0;
  logic [WAIT_W-1:0] wrWait = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic addrValid = 1'b0;
  logic [NUM_CH-1:0] selN;
  logic ackReq, hitWide;
  logic [WAIT_W-1:0] hitWait;

  always #2 clk = ~clk;

  csel_decoder u_csel_decoder (
    .clk(clk), .rstN(rstN), .bootWide(bootWide), .wrEn(wrEn), .wrChan(wrChan),
    .wrBase(wrBase), .wrSize(wrSize), .wrEnable(wrEnable), .wrPinSel(wrPinSel),
    .wrWide(wrWide), .wrWait(wrWait), .addr(addr), .addrValid(addrValid),
    .selN(selN), .ackReq(ackReq), .hitWide(hitWide), .hitWait(hitWait)
  );

  int nRun = 0, nFail = 0;
  logic [BASE_W-1:0] mBase [NUM_CH];
  logic [2:0]        mSize [NUM_CH];
  logic [WAIT_W-1:0] mWait [NUM_CH];
  logic              mEn [NUM_CH], mPin [NUM_CH], mWide [NUM_CH];
  logic [OUT_W-1:0]  lastExp;

  function automatic int lowOf(input logic [2:0] c);
    case (c)
      3'd0: return 11; 3'd1: return 13; 3'd2: return 14; 3'd3: return 16;
      3'd4: return 17; 3'd5: return 18; 3'd6: return 19; default: return 20;
    endcase
  endfunction

  function automatic logic [OUT_W-1:0] model(input logic [ADDR_W-1:0] a, input logic v);
    logic [NUM_CH-1:0] s = '1;
    logic ack = 1'b0, w = 1'b0, done = 1'b0;
    logic [WAIT_W-1:0] wt = '0;
    if (v) begin
      for (int i = 0; i < NUM_CH; i++) begin
        int lo = lowOf(mSize[i]);
        logic [ADDR_W-1:0] b = {mBase[i], 11'b0};
        if (mEn[i] && ((a >> lo) == (b >> lo))) begin
          ack = 1'b1;
          if (mPin[i]) s[i] = 1'b0;
          if (!done) begin w = mWide[i]; wt = mWait[i]; done = 1'b1; end
        end
      end
    end
    return {s, ack, w, wt};
  endfunction

  task automatic check(input string tag, input logic [OUT_W-1:0] exp);
    logic [OUT_W-1:0] got = {selN, ackReq, hitWide, hitWait};
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic vec(input logic [ADDR_W-1:0] a, input logic v, input string tag);
    addr = a; addrValid = v;
    @(negedge clk);
    lastExp = model(a, v);
    check(tag, lastExp);
  endtask

  task automatic wr(input int ch, input logic [BASE_W-1:0] b, input logic [2:0] s,
                    input logic en, input logic pin, input logic wd, input logic [WAIT_W-1:0] wt);
    wrEn = 1'b1; wrChan = CH_W'(ch); wrBase = b; wrSize = s;
    wrEnable = en; wrPinSel = pin; wrWide = wd; wrWait = wt;
    @(negedge clk);
    wrEn = 1'b0;
    mBase[ch] = b; mSize[ch] = s; mEn[ch] = en; mPin[ch] = pin; mWide[ch] = wd; mWait[ch] = wt;
  endtask

  // R9: a write held during reset must be ignored
  task automatic doReset(input logic bw);
    rstN = 1'b0; bootWide = bw; addrValid = 1'b0;
    wrEn = 1'b1; wrChan = 2'd2; wrBase = '0; wrSize = 3'd7;
    wrEnable = 1'b1; wrPinSel = 1'b1; wrWide = 1'b1; wrWait = 4'd3;
    repeat (3) @(negedge clk);
    wrEn = 1'b0; rstN = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      mBase[i] = '0; mSize[i] = (i == 0) ? 3'd7 : 3'd0; mEn[i] = (i == 0);
      mPin[i] = (i == 0); mWide[i] = (i == 0) ? bw : 1'b0; mWait[i] = (i == 0) ? '1 : '0;
    end
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset(1'b0);
    check("R5 reset outputs idle", {4'b1111, 1'b0, 1'b0, 4'h0});
    vec(24'h000000, 1'b1, "R1 R9 boot covers zero, ignored reset write");
    check("R2 narrow boot width", {4'b1110, 1'b1, 1'b0, 4'hF});
    vec(24'h07FFFF, 1'b1, "R1 boot upper window");
    vec(24'h080000, 1'b1, "R4 bit19 ignored by code 7");
    vec(24'h100000, 1'b1, "R4 bit20 compared by code 7");
    vec(24'h000000, 1'b0, "R5 invalid address idle");
    vec(24'h000000, 1'b1, "R5 registered result");
    addr = 24'h100000; addrValid = 1'b1;
    #1 check("R5 output holds until edge", lastExp);

    doReset(1'b1);
    vec(24'h000400, 1'b1, "R2 wide boot width");
    check("R2 wide boot fields", {4'b1110, 1'b1, 1'b1, 4'hF});

    wr(0, '0, 3'd7, 1'b0, 1'b1, 1'b0, 4'h0);
    wr(2, 13'h0B5A, 3'd0, 1'b0, 1'b1, 1'b1, 4'h2);
    wr(3, '0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0);
    for (int code = 0; code < 8; code++) begin
      wr(1, 13'h0B5A, 3'(code), 1'b1, 1'b1, code[0], 4'(code));
      for (int h = 0; h < (1 << BASE_W); h++) begin
        vec({13'(h), 11'((h * 37) & 2047)}, 1'b1, "R3 R4 R6 size sweep");
      end
    end

    wr(2, '0, 3'd7, 1'b0, 1'b1, 1'b1, 4'h6);
    vec(24'h000000, 1'b1, "R6 disabled channel quiet");

    wr(1, 13'h0100, 3'd3, 1'b1, 1'b1, 1'b0, 4'h5);
    wr(3, 13'h0100, 3'd0, 1'b1, 1'b0, 1'b1, 4'h5);
    vec(24'h080000, 1'b1, "R8 lowest channel wins");
    check("R8 priority fields", {4'b1101, 1'b1, 1'b0, 4'h5});
    vec(24'h080800, 1'b1, "R3 only wide window hits");
    wr(1, 13'h0100, 3'd3, 1'b0, 1'b1, 1'b0, 4'h5);
    vec(24'h080000, 1'b1, "R7 pin mode off still acks");
    check("R7 no select, ack raised", {4'b1111, 1'b1, 1'b1, 4'h5});
    vec(24'h090000, 1'b1, "R8 no match gives zero attributes");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule